// File: doc/BRIEF.md
# Receive Channel Sample Buffer with Threshold and Resync Modes

This block holds the 32-bit samples that arrive from the link side for one antenna-carrier channel and hands them to the application on a valid/ready output. It is a circular buffer with a parameterised depth and reports its fill level as a count. A mode bit selects how the output is released. In threshold mode, valid follows the fill level compared against a programmable threshold. In synchronous mode, reading starts on a resync pulse. That pulse places the read pointer a programmable number of entries behind the write pointer, which fixes the buffer latency.

A small timer is part of the block. It produces a one-cycle start pulse a programmable number of cycles after each received frame boundary. The application can feed this pulse back to the resync input, so that realignment happens at a controlled point in the frame. Overflow (write while full) and underflow (read attempt while empty) are each recorded in a sticky flag that only reset clears.

In synchronous mode the consumer holds ready high and ignores valid. The read pointer moves only in cycles where ready is high, so dropping ready stalls the output stream.

Top module: `rxChanBuf`

## Requirements
- R1: After reset the fill level is 0, valid is low, both sticky flags are low and the start pulse is low.
- R2: A write is accepted in every cycle where the buffer is not full. Words leave in the order they were written. The fill level equals accepted writes minus reads, and it reflects a write one cycle after the write strobe.
- R3: With the mode bit at 0 (threshold mode), valid is high exactly when the fill level is strictly greater than the threshold input. A word is removed in each cycle where both valid and ready are high. The resync input has no effect in this mode.
- R4: A write while the fill level equals the depth is dropped and leaves the stored contents unchanged. From the next cycle the overflow flag is high, and it stays high until reset.
- R5: With the mode bit at 1 (synchronous mode), no word is read and valid stays low until the first resync pulse, whatever the level of ready.
- R6: In synchronous mode, a resync pulse moves the read pointer to the write pointer minus the latency input. After that edge, the fill level equals the latency, plus one if a write happened in the same cycle. The head word is the one written latency writes before the resync cycle. The latency input must be below the depth.
- R7: In synchronous mode, after resync, one word is read in every cycle where ready is high and the buffer is not empty. With ready low the read pointer holds. Valid is high only while ready is high and the buffer is not empty.
- R8: In synchronous mode, after resync, a cycle with ready high and an empty buffer (and no resync) reads nothing. From the next cycle the underflow flag is high, and it stays high until reset.
- R9: A frame boundary strobe in one cycle makes the start pulse high for exactly one cycle. That pulse comes startOffset+1 cycles later. A new strobe restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides of the buffer |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | Link side write strobe |
| wrData | input | 32 | Link side sample |
| frameStart | input | 1 | Received frame boundary strobe |
| startOffset | input | 16 | Cycles from frame boundary to start pulse, minus one |
| startPulse | output | 1 | One-cycle start pulse |
| syncMode | input | 1 | 0 selects threshold mode, 1 selects synchronous mode |
| readyThr | input | 5 | Fill threshold for valid in threshold mode |
| latencyDepth | input | 5 | Entries kept between read and write pointer on resync |
| resync | input | 1 | Realignment pulse for synchronous mode |
| outReady | input | 1 | Consumer ready |
| outValid | output | 1 | Output word available |
| outData | output | 32 | Head word of the buffer |
| fillLevel | output | 5 | Number of stored words |
| overflow | output | 1 | Sticky write-while-full flag |
| underflow | output | 1 | Sticky read-while-empty flag |

## Verification
In synchronous mode, a write and a realignment can fall in the same cycle, and so can a write and a read. The bench provokes the first by raising resync in the cycle that carries a new sample. It judges the result by checking that the fill level lands on latency plus one and that the head word is the one expected. It then streams a write and a read in every cycle with ready high. Across those cycles the fill level must stay constant while the output words follow the input stream exactly that many entries behind.

// File: rtl/rxChanBufPkg.sv
package rxChanBufPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic realign;
  } bufStrobe_t;
endpackage

// File: rtl/rxBufData.sv
module rxBufData
  import rxChanBufPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  latencyDepth,
  output logic [DATA_W-1:0] outData,
  output logic [CNT_W-1:0]  fillLevel
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] store [DEPTH];
  logic [CNT_W-1:0]  wrPtr;
  logic [CNT_W-1:0]  rdPtr;

  always_ff @(posedge clk) begin
    if (strobe.push) store[wrPtr[AW-1:0]] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + 1'b1;
      if (strobe.realign)  rdPtr <= wrPtr - latencyDepth;
      else if (strobe.pop) rdPtr <= rdPtr + 1'b1;
    end
  end

  assign fillLevel = wrPtr - rdPtr;
  assign outData   = store[rdPtr[AW-1:0]];
endmodule

// File: rtl/rxBufCtrl.sv
module rxBufCtrl
  import rxChanBufPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic             syncMode,
  input  logic             resync,
  input  logic             outReady,
  input  logic [CNT_W-1:0] readyThr,
  input  logic [CNT_W-1:0] fillLevel,
  output bufStrobe_t       strobe,
  output logic             outValid,
  output logic             overflow,
  output logic             underflow
);
  logic isFull;
  logic isEmpty;
  logic running;
  logic thrValid;
  logic syncRead;
  logic readStarved;

  assign isFull   = (fillLevel == CNT_W'(DEPTH));
  assign isEmpty  = (fillLevel == '0);
  assign thrValid = (fillLevel > readyThr);

  // synchronous mode read attempt after realignment
  assign syncRead    = syncMode && running && outReady && !resync;
  assign readStarved = syncRead && isEmpty;

  always_comb begin
    strobe.push    = wrValid && !isFull;
    strobe.realign = syncMode && resync;
    if (syncMode) strobe.pop = syncRead && !isEmpty;
    else          strobe.pop = thrValid && outReady;
    if (syncMode) outValid = running && outReady && !isEmpty;
    else          outValid = thrValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (!syncMode)   running <= 1'b0;
      else if (resync) running <= 1'b1;
      if (wrValid && isFull) overflow  <= 1'b1;
      if (readStarved)       underflow <= 1'b1;
    end
  end
endmodule

// File: rtl/rxStartTimer.sv
module rxStartTimer #(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic [OFS_W-1:0] startOffset,
  output logic             startPulse
);
  logic [OFS_W-1:0] remain;
  logic             armed;

  assign startPulse = armed && (remain == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= '0;
      armed  <= 1'b0;
    end else if (frameStart) begin
      remain <= startOffset;
      armed  <= 1'b1;
    end else if (armed) begin
      if (remain == '0) armed <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/rxChanBuf.sv
module rxChanBuf
  import rxChanBufPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int OFS_W  = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              frameStart,
  input  logic [OFS_W-1:0]  startOffset,
  output logic              startPulse,
  input  logic              syncMode,
  input  logic [CNT_W-1:0]  readyThr,
  input  logic [CNT_W-1:0]  latencyDepth,
  input  logic              resync,
  input  logic              outReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [CNT_W-1:0]  fillLevel,
  output logic              overflow,
  output logic              underflow
);
  bufStrobe_t strobe;

  rxBufCtrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .syncMode(syncMode),
    .resync(resync), .outReady(outReady), .readyThr(readyThr),
    .fillLevel(fillLevel), .strobe(strobe), .outValid(outValid),
    .overflow(overflow), .underflow(underflow)
  );

  rxBufData #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .latencyDepth(latencyDepth), .outData(outData), .fillLevel(fillLevel)
  );

  rxStartTimer #(.OFS_W(OFS_W)) u_timer (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .startOffset(startOffset), .startPulse(startPulse)
  );
endmodule

// File: rtl/rxChanBufChecker.sv
module rxChanBufChecker #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrValid,
  input logic             resync,
  input logic             syncMode,
  input logic             outReady,
  input logic             outValid,
  input logic [CNT_W-1:0] readyThr,
  input logic [CNT_W-1:0] fillLevel,
  input logic             overflow,
  input logic             underflow,
  input logic             frameStart,
  input logic             startPulse
);
  a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= CNT_W'(DEPTH));

  a_r2_fill_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!outReady && !resync && !wrValid) |=> $stable(fillLevel));

  a_r3_valid_above_thr: assert property (@(posedge clk) disable iff (!rstN)
    (!syncMode && outValid) |-> (fillLevel > readyThr));

  a_r4_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  a_r7_valid_needs_ready: assert property (@(posedge clk) disable iff (!rstN)
    (syncMode && outValid) |-> (outReady && fillLevel != '0));

  a_r8_underflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> underflow);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !frameStart) |=> !startPulse);
endmodule

bind rxChanBuf rxChanBufChecker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .resync(resync),
  .syncMode(syncMode), .outReady(outReady), .outValid(outValid),
  .readyThr(readyThr), .fillLevel(fillLevel), .overflow(overflow),
  .underflow(underflow), .frameStart(frameStart), .startPulse(startPulse)
);

// File: tb/tb_rxChanBuf.sv
module tb_rxChanBuf;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [31:0] wrData = '0;
  logic        frameStart = 1'b0;
  logic [15:0] startOffset = '0;
  logic        startPulse;
  logic        syncMode = 1'b0;
  logic [CNT_W-1:0] readyThr = '0;
  logic [CNT_W-1:0] latencyDepth = '0;
  logic        resync = 1'b0;
  logic        outReady = 1'b0;
  logic        outValid;
  logic [31:0] outData;
  logic [CNT_W-1:0] fillLevel;
  logic        overflow;
  logic        underflow;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rxChanBuf dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .frameStart(frameStart), .startOffset(startOffset), .startPulse(startPulse),
    .syncMode(syncMode), .readyThr(readyThr), .latencyDepth(latencyDepth),
    .resync(resync), .outReady(outReady), .outValid(outValid),
    .outData(outData), .fillLevel(fillLevel), .overflow(overflow),
    .underflow(underflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic pushWords(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      wrValid = 1'b1;
      wrData  = base + i;
      step();
    end
    wrValid = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 fill", 32'(fillLevel), 0);
    chk("R1 valid", 32'(outValid), 0);
    chk("R1 overflow", 32'(overflow), 0);
    chk("R1 underflow", 32'(underflow), 0);
    chk("R1 pulse", 32'(startPulse), 0);
  endtask

  task automatic testThreshold();
    syncMode = 1'b0; readyThr = 5'd3; outReady = 1'b0;
    pushWords(3, 32'hA000_0000);
    chk("R2 fill after 3", 32'(fillLevel), 3);
    chk("R3 valid at thr", 32'(outValid), 0);
    pushWords(1, 32'hA000_0003);
    chk("R3 valid above thr", 32'(outValid), 1);
    chk("R2 head", outData, 32'hA000_0000);
    resync = 1'b1; latencyDepth = 5'd1;
    step();
    resync = 1'b0;
    chk("R3 resync ignored", 32'(fillLevel), 4);
    chk("R3 head kept", outData, 32'hA000_0000);
    outReady = 1'b1;
    step();
    chk("R3 one pop", 32'(fillLevel), 3);
    chk("R3 valid dropped", 32'(outValid), 0);
    readyThr = 5'd0;
    for (int k = 0; k < 3; k++) begin
      chk("R2 order", outData, 32'hA000_0001 + k);
      step();
    end
    chk("R2 drained", 32'(fillLevel), 0);
    chk("R3 empty no valid", 32'(outValid), 0);
    outReady = 1'b0;
  endtask

  task automatic testOverflow();
    readyThr = 5'd16; outReady = 1'b0;
    pushWords(DEPTH + 2, 32'hB000_0000);
    chk("R4 fill capped", 32'(fillLevel), DEPTH);
    chk("R4 overflow set", 32'(overflow), 1);
    chk("R8 no underflow", 32'(underflow), 0);
    readyThr = 5'd0; outReady = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      chk("R4 kept words", outData, 32'hB000_0000 + k);
      step();
    end
    chk("R4 nothing extra", 32'(fillLevel), 0);
    chk("R4 sticky", 32'(overflow), 1);
    outReady = 1'b0;
  endtask

  task automatic testSyncAlign();
    syncMode = 1'b1; outReady = 1'b1;
    pushWords(10, 32'hC000_0000);
    chk("R5 no read before resync", 32'(fillLevel), 10);
    chk("R5 valid low", 32'(outValid), 0);
    resync = 1'b1; latencyDepth = 5'd4;
    step();
    resync = 1'b0;
    chk("R6 fill equals latency", 32'(fillLevel), 4);
    chk("R6 head word", outData, 32'hC000_0006);
    chk("R7 valid", 32'(outValid), 1);
    for (int k = 0; k < 4; k++) begin
      chk("R7 stream", outData, 32'hC000_0006 + k);
      step();
    end
    chk("R7 empty", 32'(fillLevel), 0);
    chk("R7 valid empty", 32'(outValid), 0);
    chk("R8 not yet", 32'(underflow), 0);
    step();
    chk("R8 underflow set", 32'(underflow), 1);
    chk("R8 fill stays 0", 32'(fillLevel), 0);
  endtask

  task automatic testSyncHold();
    outReady = 1'b0;
    pushWords(2, 32'hD000_0000);
    chk("R7 hold fill", 32'(fillLevel), 2);
    chk("R7 valid needs ready", 32'(outValid), 0);
    step();
    chk("R7 hold stays", 32'(fillLevel), 2);
    outReady = 1'b1;
    #1;
    chk("R7 valid with ready", 32'(outValid), 1);
    chk("R7 head after hold", outData, 32'hD000_0000);
    outReady = 1'b0;
  endtask

  task automatic testSyncCombined();
    pushWords(6, 32'hE000_0000);
    chk("R2 fill before realign", 32'(fillLevel), 8);
    wrValid = 1'b1; wrData = 32'hE000_0006;
    resync = 1'b1; latencyDepth = 5'd4;
    step();
    resync = 1'b0;
    chk("R6 fill with write", 32'(fillLevel), 5);
    chk("R6 head with write", outData, 32'hE000_0002);
    outReady = 1'b1;
    for (int k = 0; k < 6; k++) begin
      wrData = 32'hE000_0007 + k;
      #1;
      chk("R7 steady fill", 32'(fillLevel), 5);
      chk("R7 steady data", outData, 32'hE000_0002 + k);
      step();
    end
    wrValid = 1'b0; outReady = 1'b0;
  endtask

  task automatic testTimer(input logic [15:0] ofs);
    int k;
    startOffset = ofs;
    frameStart = 1'b1;
    step();
    frameStart = 1'b0;
    k = 1;
    while (!startPulse && k < 40) begin
      step();
      k++;
    end
    chk("R9 pulse delay", 32'(k), 32'(ofs) + 1);
    step();
    chk("R9 pulse width", 32'(startPulse), 0);
  endtask

  task automatic testTimerRestart();
    startOffset = 16'd5;
    frameStart = 1'b1;
    step();
    frameStart = 1'b0;
    step(); step();
    startOffset = 16'd2;
    frameStart = 1'b1;
    step();
    frameStart = 1'b0;
    chk("R9 restart no early pulse", 32'(startPulse), 0);
    step();
    chk("R9 restart quiet", 32'(startPulse), 0);
    step();
    chk("R9 restart pulse", 32'(startPulse), 1);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    step();
    step();
    testReset();
    rstN = 1'b1;
    step();
    testReset();
    testThreshold();
    testOverflow();
    testSyncAlign();
    testSyncHold();
    testSyncCombined();
    testTimer(16'd3);
    testTimer(16'd0);
    testTimerRestart();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule